// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This engine turns one-bit-per-pixel bitmap data, such as font glyphs, into 8-bit colour pixel writes for a linear frame buffer. The host first programs a span: a row, a first column and an inclusive last column. It also sets two colours, a plane mask and per-word step values. Writing a 32-bit bitmap word then starts the expansion. Each bit, most significant first, becomes one pixel write carrying a frame buffer address and a colour.

Pixel writes leave through a valid/ready stream, one per cycle when the sink accepts. After each word the span's columns and row move by the programmed steps. A glyph row wider than one word can therefore be sent as a run of bitmap words without reprogramming coordinates. While a word is being expanded, the engine reports busy and ignores all register writes.

Top module: `glyph_expander`

## Requirements
- R1: Register writes use `wr_sel`: 0 row, 1 first column, 2 last column, 3 set-bit colour, 4 clear-bit colour, 5 plane mask, 6 column step, 7 row step, 8 bitmap word. After reset, busy and pix_valid are low, every coordinate and the row step are 0, the column step is 32, the set-bit colour and plane mask are all ones, and the clear-bit colour is 0.
- R2: A write to the bitmap word while idle starts a span. Busy is high from the next cycle until the cycle after the span's last pixel is accepted.
- R3: Pixel i of a span (i from 0) is taken from bit 31−i of the word. It is written to address row × PITCH + first column + i, and accepted pixels have consecutive addresses.
- R4: The span holds (last − first + 1) pixels and uses only that many top bits. A span wider than 32 is cut to 32 pixels. A last column below the first column gives no pixels and busy stays low.
- R5: A set bit gives the set-bit colour and a clear bit gives the clear-bit colour, each ANDed with the plane mask.
- R6: One pixel is offered at a time. While pix_valid is high and pix_ready is low, the address and colour hold steady.
- R7: Each accepted bitmap word adds the column step to both the first and last column and the row step to the row, modulo 2^12. The next word then continues from there.
- R8: While busy, writes to every register, including the bitmap word, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register selector |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | Span expansion in progress |
| pix_valid | output | 1 | Pixel write offered |
| pix_ready | input | 1 | Sink accepts the offered pixel |
| pix_addr | output | 24 | Frame buffer pixel address |
| pix_color | output | 8 | Masked pixel colour |

## Verification
The address-step property assumes that no span runs past column 4095. Past that point the column wraps and the address would not rise by one. Every stimulus span therefore stays well inside the coordinate range. The checks on register locking and mask legality rely on the host respecting busy only through the engine's own write gating. The bench deliberately issues writes during busy to exercise that gate. Stall patterns on pix_ready are chosen so that every span drains within a few dozen cycles.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    localparam int GX_COORD_W = 12;
    localparam int GX_COLOR_W = 8;
    localparam int GX_WORD_W  = 32;
    localparam int GX_CNT_W   = $clog2(GX_WORD_W + 1);
    localparam int GX_SEL_W   = 4;

    typedef logic [GX_COORD_W-1:0] coord_t;
    typedef logic [GX_COLOR_W-1:0] color_t;
    typedef logic [GX_WORD_W-1:0]  word_t;
    typedef logic [GX_CNT_W-1:0]   cnt_t;

    typedef enum logic [GX_SEL_W-1:0] {
        SEL_ROW   = 4'd0,
        SEL_XFST  = 4'd1,
        SEL_XLST  = 4'd2,
        SEL_FG    = 4'd3,
        SEL_BG    = 4'd4,
        SEL_MASK  = 4'd5,
        SEL_XSTEP = 4'd6,
        SEL_YSTEP = 4'd7,
        SEL_WORD  = 4'd8
    } reg_sel_e;

    typedef struct packed {
        word_t  bits;
        coord_t x;
        coord_t y;
        cnt_t   len;
        color_t fg;
        color_t bg;
        color_t mask;
    } span_t;

    // Pixel count of a span: inclusive bounds, capped at one word, empty when reversed.
    function automatic cnt_t span_len(coord_t xs, coord_t xe);
        coord_t d;
        if (xe < xs) return '0;
        d = xe - xs;
        if (d >= coord_t'(GX_WORD_W - 1)) return cnt_t'(GX_WORD_W);
        return cnt_t'(d) + cnt_t'(1);
    endfunction

    function automatic color_t pick_color(logic b, color_t fg, color_t bg, color_t mask);
        return (b ? fg : bg) & mask;
    endfunction

endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [GX_SEL_W-1:0] wr_sel,
    input  logic [31:0]         wr_data,
    input  logic                busy,
    output logic                start,
    output span_t               span
);

    coord_t row_q, xfst_q, xlst_q, xstep_q, ystep_q;
    color_t fg_q, bg_q, mask_q;
    logic   accept;

    assign accept = wr_en && !busy;
    assign start  = accept && (wr_sel == SEL_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= '0;
            xfst_q  <= '0;
            xlst_q  <= '0;
            xstep_q <= coord_t'(GX_WORD_W);
            ystep_q <= '0;
            fg_q    <= '1;
            bg_q    <= '0;
            mask_q  <= '1;
        end else if (accept) begin
            case (reg_sel_e'(wr_sel))
                SEL_ROW:   row_q   <= wr_data[GX_COORD_W-1:0];
                SEL_XFST:  xfst_q  <= wr_data[GX_COORD_W-1:0];
                SEL_XLST:  xlst_q  <= wr_data[GX_COORD_W-1:0];
                SEL_FG:    fg_q    <= wr_data[GX_COLOR_W-1:0];
                SEL_BG:    bg_q    <= wr_data[GX_COLOR_W-1:0];
                SEL_MASK:  mask_q  <= wr_data[GX_COLOR_W-1:0];
                SEL_XSTEP: xstep_q <= wr_data[GX_COORD_W-1:0];
                SEL_YSTEP: ystep_q <= wr_data[GX_COORD_W-1:0];
                SEL_WORD: begin
                    xfst_q <= xfst_q + xstep_q;
                    xlst_q <= xlst_q + xstep_q;
                    row_q  <= row_q + ystep_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        span.bits = wr_data;
        span.x    = xfst_q;
        span.y    = row_q;
        span.len  = span_len(xfst_q, xlst_q);
        span.fg   = fg_q;
        span.bg   = bg_q;
        span.mask = mask_q;
    end

endmodule

// File: rtl/glyph_shifter.sv
module glyph_shifter
    import glyph_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  span_t  span_in,
    input  logic   pix_ready,
    output logic   pix_valid,
    output coord_t pix_x,
    output coord_t pix_y,
    output color_t pix_color,
    output logic   busy
);

    word_t  bits_q;
    coord_t x_q, y_q;
    cnt_t   left_q;
    color_t fg_q, bg_q, mask_q;
    logic   take;

    assign pix_valid = (left_q != '0);
    assign busy      = pix_valid;
    assign take      = pix_valid && pix_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            left_q <= '0;
            fg_q   <= '0;
            bg_q   <= '0;
            mask_q <= '0;
        end else if (start && !pix_valid) begin
            bits_q <= span_in.bits;
            x_q    <= span_in.x;
            y_q    <= span_in.y;
            left_q <= span_in.len;
            fg_q   <= span_in.fg;
            bg_q   <= span_in.bg;
            mask_q <= span_in.mask;
        end else if (take) begin
            bits_q <= {bits_q[GX_WORD_W-2:0], 1'b0};
            x_q    <= x_q + coord_t'(1);
            left_q <= left_q - cnt_t'(1);
        end
    end

    assign pix_x     = x_q;
    assign pix_y     = y_q;
    assign pix_color = pick_color(bits_q[GX_WORD_W-1], fg_q, bg_q, mask_q);

endmodule

// File: rtl/glyph_addr.sv
module glyph_addr
    import glyph_pkg::*;
#(
    parameter int PITCH  = 1024,
    parameter int ADDR_W = 24
) (
    input  coord_t            x,
    input  coord_t            y,
    output logic [ADDR_W-1:0] addr
);

    localparam bit POW2  = (PITCH & (PITCH - 1)) == 0;
    localparam int SHIFT = $clog2(PITCH);

    generate
        if (POW2) begin : g_shift
            assign addr = (ADDR_W'(y) << SHIFT) + ADDR_W'(x);
        end else begin : g_mul
            assign addr = ADDR_W'(y) * ADDR_W'(PITCH) + ADDR_W'(x);
        end
    endgenerate

endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
    import glyph_pkg::*;
#(
    parameter int PITCH  = 1024,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic              busy,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [ADDR_W-1:0] pix_addr,
    output logic [7:0]        pix_color
);

    span_t  span_w;
    logic   start_w;
    coord_t px_w, py_w;

    glyph_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .busy    (busy),
        .start   (start_w),
        .span    (span_w)
    );

    glyph_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .span_in   (span_w),
        .pix_ready (pix_ready),
        .pix_valid (pix_valid),
        .pix_x     (px_w),
        .pix_y     (py_w),
        .pix_color (pix_color),
        .busy      (busy)
    );

    glyph_addr #(.PITCH(PITCH), .ADDR_W(ADDR_W)) u_addr (
        .x    (px_w),
        .y    (py_w),
        .addr (pix_addr)
    );

endmodule

// File: rtl/glyph_expander_chk.sv
module glyph_expander_chk
    import glyph_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [ADDR_W-1:0] pix_addr,
    input logic [7:0]        pix_color,
    input coord_t            cfg_x,
    input coord_t            cfg_y,
    input cnt_t              cfg_len,
    input color_t            cfg_fg,
    input color_t            cfg_bg,
    input color_t            cfg_mask
);

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_addr) && $stable(pix_color));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        pix_valid && pix_ready |=> !pix_valid || (pix_addr == ADDR_W'($past(pix_addr) + 1'b1)));

    a_r5_mask_legal: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ((pix_color & ~cfg_mask) == '0));

    a_r2_busy_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pix_valid && pix_ready));

    a_r8_regs_locked: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_x) && $stable(cfg_y) && $stable(cfg_len)
                 && $stable(cfg_fg) && $stable(cfg_bg) && $stable(cfg_mask));

endmodule

bind glyph_expander glyph_expander_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_addr  (pix_addr),
    .pix_color (pix_color),
    .cfg_x     (span_w.x),
    .cfg_y     (span_w.y),
    .cfg_len   (span_w.len),
    .cfg_fg    (span_w.fg),
    .cfg_bg    (span_w.bg),
    .cfg_mask  (span_w.mask)
);

// File: tb/glyph_expander_tb.sv
`timescale 1ns/1ps
module glyph_expander_tb;

    localparam int PITCH = 1024;
    localparam int NV    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        busy, pix_valid;
    logic        pix_ready = 1'b1;
    logic [23:0] pix_addr;
    logic [7:0]  pix_color;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    glyph_expander u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_addr(pix_addr), .pix_color(pix_color)
    );

    always #2.5 clk = ~clk;

    // Vector table: row, first, last, set colour, clear colour, mask, word, stall
    localparam int          TV_Y   [NV] = '{3, 7, 0, 20, 1, 2};
    localparam int          TV_X0  [NV] = '{10, 100, 0, 500, 200, 50};
    localparam int          TV_X1  [NV] = '{41, 104, 15, 500, 300, 40};
    localparam logic [7:0]  TV_FG  [NV] = '{8'hA5, 8'h11, 8'hFF, 8'h77, 8'hC3, 8'h01};
    localparam logic [7:0]  TV_BG  [NV] = '{8'h3C, 8'hEE, 8'h00, 8'h5A, 8'h18, 8'h02};
    localparam logic [7:0]  TV_MSK [NV] = '{8'hFF, 8'hF0, 8'h0F, 8'hFF, 8'h7E, 8'hFF};
    localparam logic [31:0] TV_W   [NV] = '{32'h8000_0001, 32'hF800_0000, 32'hAAAA_5555,
                                            32'h0000_0000, 32'hDEAD_BEEF, 32'hFFFF_FFFF};
    localparam bit          TV_ST  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] s, logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(int y, int x0, int x1, logic [7:0] fg, logic [7:0] bg, logic [7:0] m);
        wr(4'd0, 32'(y));
        wr(4'd1, 32'(x0));
        wr(4'd2, 32'(x1));
        wr(4'd3, {24'd0, fg});
        wr(4'd4, {24'd0, bg});
        wr(4'd5, {24'd0, m});
    endtask

    function automatic int width_of(int x0, int x1);
        if (x1 < x0) return 0;
        if (x1 - x0 + 1 > 32) return 32;
        return x1 - x0 + 1;
    endfunction

    // Called at the falling edge right after the bitmap word write.
    task automatic collect(string tag, int n, int y, int x0, logic [31:0] w,
                           logic [7:0] fg, logic [7:0] bg, logic [7:0] m, bit stall);
        int idx = 0;
        int guard = 0;
        int phase = 0;
        if (n > 0) chk(busy == 1'b1, "R2", "busy after word write", busy, 1);
        while (idx < n && guard < 400) begin
            pix_ready = stall ? (phase % 3 != 1) : 1'b1;
            phase++;
            if (pix_valid && pix_ready) begin
                logic [23:0] ea;
                logic [7:0]  ec;
                ea = 24'(y * PITCH + x0 + idx);
                ec = (w[31-idx] ? fg : bg) & m;
                chk(pix_addr == ea, tag, "pixel address", pix_addr, ea);
                chk(pix_color == ec, tag, "pixel colour", pix_color, ec);
                idx++;
            end
            @(negedge clk);
            guard++;
        end
        chk(idx == n, tag, "pixel count", idx, n);
        chk(busy == 1'b0 && pix_valid == 1'b0, "R2", "idle after span", {busy, pix_valid}, 0);
        pix_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and defaults
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(pix_valid == 1'b0, "R1", "pix_valid after reset", pix_valid, 0);
        wr(4'd8, 32'h8000_0000);
        collect("R1", 1, 0, 0, 32'h8000_0000, 8'hFF, 8'h00, 8'hFF, 1'b0);
        // R1/R7: default column step of 32
        wr(4'd8, 32'h0000_0000);
        collect("R7", 1, 0, 32, 32'h0000_0000, 8'hFF, 8'h00, 8'hFF, 1'b0);

        // Table walk: R3 ordering, R4 width, R5 colours, R6 stalls
        for (int i = 0; i < NV; i++) begin
            prog(TV_Y[i], TV_X0[i], TV_X1[i], TV_FG[i], TV_BG[i], TV_MSK[i]);
            wr(4'd8, TV_W[i]);
            collect(i == 5 ? "R4" : (TV_ST[i] ? "R6" : "R3"),
                    width_of(TV_X0[i], TV_X1[i]), TV_Y[i], TV_X0[i],
                    TV_W[i], TV_FG[i], TV_BG[i], TV_MSK[i], TV_ST[i]);
        end

        // R7: auto-advance of columns and row with programmed steps
        prog(5, 64, 95, 8'h81, 8'h42, 8'hFF);
        wr(4'd6, 32'd40);
        wr(4'd7, 32'd2);
        wr(4'd8, 32'h1234_5678);
        collect("R7", 32, 5, 64, 32'h1234_5678, 8'h81, 8'h42, 8'hFF, 1'b0);
        wr(4'd8, 32'h8765_4321);
        collect("R7", 32, 7, 104, 32'h8765_4321, 8'h81, 8'h42, 8'hFF, 1'b1);

        // R8: writes while busy are ignored; R6 outputs hold while stalled
        prog(9, 0, 3, 8'h55, 8'h22, 8'hFF);
        wr(4'd6, 32'd32);
        wr(4'd7, 32'd0);
        pix_ready = 1'b0;
        wr(4'd8, 32'hA000_0000);
        chk(pix_valid == 1'b1, "R6", "valid while stalled", pix_valid, 1);
        chk(pix_addr == 24'(9 * PITCH), "R6", "first address", pix_addr, 9 * PITCH);
        wr(4'd3, 32'h99);
        wr(4'd1, 32'd700);
        wr(4'd8, 32'hFFFF_FFFF);
        chk(pix_addr == 24'(9 * PITCH), "R6", "address held under stall", pix_addr, 9 * PITCH);
        chk(pix_color == 8'h55, "R6", "colour held under stall", pix_color, 8'h55);
        collect("R8", 4, 9, 0, 32'hA000_0000, 8'h55, 8'h22, 8'hFF, 1'b0);
        wr(4'd8, 32'hF000_0000);
        collect("R8", 4, 9, 32, 32'hF000_0000, 8'h55, 8'h22, 8'hFF, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule